// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM of 8192 words by 8 bits. The host offers one word at a time on a valid/ready request port: an address, write data and a write flag. The controller converts each accepted request into a complete RAM cycle. It drives a pair of chip enables of opposite polarity, an active-low write strobe and an active-low output enable, and it shares one bidirectional data bus with the RAM.

Each phase length is a whole number of clock cycles. It is computed at elaboration as the ceiling of a nanosecond figure divided by the clock-period parameter, with a floor of one cycle. The write cycle is controlled by the write strobe, with output enable held high. The controller's data driver turns on only after the RAM's output-disable window has passed. It releases the bus one cycle after the strobe rises. A read returns its word with a one-cycle valid pulse, and a write returns a one-cycle acknowledge.

The cycle counts below apply to the default 4 ns clock period.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: In reset and while idle, the controller holds the following state. `ram_ce_n` is 1 and `ram_ce` is 0. `ram_we_n` and `ram_oe_n` are both 1. The data driver is off. `req_ready` is 1, and `rd_valid` and `wr_ack` are 0.
- R2: A request is accepted on a rising clock edge only when `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the cycle ends, which is 18 cycles later. While `req_ready` is low, a request that stays asserted starts no RAM activity.
- R3: For a write (`req_write` = 1), `ram_we_n` goes low at the edge of acceptance and stays low for 17 consecutive cycles, which is at least 50 ns. `ram_oe_n` stays high for the whole write. The RAM stores the word when `ram_we_n` rises.
- R4: The controller drives the write data onto `ram_dq` from 8 cycles after `ram_we_n` falls. This is at least 30 ns, which covers both the 30 ns disable window of the write strobe and the 25 ns disable window of output enable. The data is therefore stable for 9 cycles, at least 35 ns, before `ram_we_n` rises. The driver releases the bus one cycle after that rise, and it is never on while `ram_oe_n` is low.
- R5: `ram_addr` holds the accepted address from acceptance until the cycle ends. It never changes while `ram_we_n` is low.
- R6: `wr_ack` is a one-cycle pulse. It rises at the same edge as `ram_we_n`, 17 cycles after acceptance.
- R7: For a read, `ram_oe_n` goes low and `ram_we_n` stays high from acceptance. The bus is sampled at the 18th edge after acceptance, which is at least 70 ns after the address and at least 40 ns after output enable falls. At that edge `rd_data` is loaded, `rd_valid` pulses for one cycle and `ram_oe_n` returns high.
- R8: Every read or write keeps the chip enabled for 18 cycles, which is at least 70 ns. After that both enables return to their inactive levels.
- R9: `ram_we_n` or `ram_oe_n` is low only while the RAM is selected, meaning `ram_ce_n` is low and `ram_ce` is high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Data for a write |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` holds the read word |
| rd_data | output | 8 | Last word read |
| wr_ack | output | 1 | One-cycle pulse when the write strobe rises |
| ram_addr | output | 13 | RAM address |
| ram_ce_n | output | 1 | RAM enable, active low |
| ram_ce | output | 1 | RAM enable, active high |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq | inout | 8 | Shared RAM data bus |

## Verification
The assertions check on every cycle the following properties:
- The strobes assert only while the RAM is selected.
- Write and read strobes never overlap.
- The data driver is off when the write strobe falls and stays off while output enable is low.
- The driver turns off the cycle after the strobe rises.
- The address stays frozen under a low write strobe.
- The write strobe reaches its minimum low width.
- The acknowledge coincides with the strobe's rise.

Several properties can be shown only by the bench's scenarios with its timed RAM model:
- The exact read sampling edge. The model returns corrupted data until its access time has elapsed.
- The number of cycles the write data sits on the bus before the strobe rises.
- That the stored and returned words are correct, including at the top address.
- That a request held during a busy cycle waits its turn.

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl #(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_WC_NS       = 70,
  parameter int T_RC_NS       = 70,
  parameter int T_WP_NS       = 50,
  parameter int T_DS_NS       = 35,
  parameter int T_AA_NS       = 70,
  parameter int T_OE_NS       = 40,
  parameter int T_HZWE_NS     = 30,
  parameter int T_HZOE_NS     = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_ack,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_ce,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  inout  wire  [DATA_W-1:0] ram_dq
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WP_C   = cyc(T_WP_NS);
  localparam int DRV_C  = imax(cyc(T_HZWE_NS), cyc(T_HZOE_NS));
  localparam int WE_C   = imax(WP_C, DRV_C + cyc(T_DS_NS));
  localparam int WREC_C = imax(1, cyc(T_WC_NS) - WE_C);
  localparam int RD_C   = imax(cyc(T_RC_NS), imax(cyc(T_AA_NS), cyc(T_OE_NS)));
  localparam int CNT_W  = $clog2(imax(WE_C, imax(WREC_C, RD_C)) + 1);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_WREC, S_RD} state_t;

  state_t            st;
  logic [CNT_W-1:0]  cnt;
  logic              ce_act;
  logic              drv_en;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready = (st == S_IDLE);
  assign ram_ce_n  = ~ce_act;
  assign ram_ce    = ce_act;
  assign ram_dq    = drv_en ? wdata_q : {DATA_W{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ce_act   <= 1'b0;
      drv_en   <= 1'b0;
      ram_we_n <= 1'b1;
      ram_oe_n <= 1'b1;
      ram_addr <= '0;
      wdata_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      wr_ack   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      wr_ack   <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          ram_addr <= req_addr;
          cnt      <= '0;
          ce_act   <= 1'b1;
          if (req_write) begin
            wdata_q  <= req_wdata;
            ram_we_n <= 1'b0;
            st       <= S_WR;
          end else begin
            ram_oe_n <= 1'b0;
            st       <= S_RD;
          end
        end
        S_WR: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(DRV_C - 1)) drv_en <= 1'b1;
          if (cnt == CNT_W'(WE_C - 1)) begin
            ram_we_n <= 1'b1;
            wr_ack   <= 1'b1;
            cnt      <= '0;
            st       <= S_WREC;
          end
        end
        S_WREC: begin
          drv_en <= 1'b0;
          cnt    <= cnt + 1'b1;
          if (cnt == CNT_W'(WREC_C - 1)) begin
            ce_act <= 1'b0;
            st     <= S_IDLE;
          end
        end
        S_RD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(RD_C - 1)) begin
            rd_data  <= ram_dq;
            rd_valid <= 1'b1;
            ram_oe_n <= 1'b1;
            ce_act   <= 1'b0;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W = 13,
  parameter int WE_MIN = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              wr_ack,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_ce_n,
  input logic              ram_ce,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic              drv_en
);

  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_cnt <= '0;
    else if (!ram_we_n) low_cnt <= low_cnt + 1'b1;
    else                low_cnt <= '0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce_n && !ram_ce && ram_we_n && ram_oe_n && !drv_en));

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n || !ram_oe_n) |-> !req_ready);

  assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (low_cnt >= 16'(WE_MIN)));

  assert_no_rw_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> ram_oe_n);

  assert_drv_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_we_n) |-> !drv_en);

  assert_drv_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |=> !drv_en);

  assert_drv_oe_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> ram_oe_n);

  assert_addr_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |=> $stable(ram_addr));

  assert_ack_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> $rose(ram_we_n));

  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_strobe_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n || !ram_oe_n) |-> (!ram_ce_n && ram_ce));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W), .WE_MIN(WP_C)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .wr_ack(wr_ack), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_ce(ram_ce),
  .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .drv_en(drv_en)
);

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;

  localparam int WE_LOW = 17;
  localparam int DRV_ON = 9;
  localparam int CYC    = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid, wr_ack;
  logic [7:0]  rd_data;
  logic [12:0] ram_addr;
  logic        ram_ce_n, ram_ce, ram_we_n, ram_oe_n;
  wire  [7:0]  ram_dq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sram_strobe_ctrl i_sram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_ack(wr_ack),
    .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_ce(ram_ce),
    .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_dq(ram_dq)
  );

  // RAM model: read data is corrupted until access time has elapsed
  logic [7:0] mem [0:8191];
  logic       sel, ram_drv;
  logic [7:0] ram_out;
  int         age = 0;

  function automatic logic [7:0] init_val(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h96;
  endfunction

  initial for (int i = 0; i < 8192; i++) mem[i] = init_val(13'(i));

  assign sel     = !ram_ce_n && ram_ce;
  assign ram_drv = sel && ram_we_n && !ram_oe_n;
  always_comb ram_out = (age >= CYC - 1) ? mem[ram_addr] : ~mem[ram_addr];
  assign ram_dq  = ram_drv ? ram_out : 8'bz;

  always @(posedge clk) age <= ram_drv ? age + 1 : 0;
  always @(posedge ram_we_n) if (sel) mem[ram_addr] = ram_dq;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic issue(input bit w, input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ram_ce_n && !ram_ce && ram_we_n && ram_oe_n, "R1 enables/strobes in reset",
          {ram_ce_n, ram_ce, ram_we_n, ram_oe_n}, 4'b1011);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready && !rd_valid && !wr_ack, "R1 idle handshake",
          {req_ready, rd_valid, wr_ack}, 3'b100);
    check(ram_ce_n && !ram_ce && ram_we_n && ram_oe_n, "R1 idle strobes",
          {ram_ce_n, ram_ce, ram_we_n, ram_oe_n}, 4'b1011);
  endtask

  task automatic t_write(input logic [12:0] a, input logic [7:0] d);
    int n = 0, lows = 0, drv = 0, bad_oe = 0, bad_addr = 0, bad_ce = 0, ce_cyc = 0;
    issue(1'b1, a, d);
    while (!wr_ack && n < 100) begin
      if (!ram_we_n) lows++;
      if (!ram_we_n && ram_dq === d) drv++;
      if (!ram_oe_n) bad_oe++;
      if (ram_addr !== a) bad_addr++;
      if (!ram_we_n && !sel) bad_ce++;
      if (sel) ce_cyc++;
      n++;
      @(negedge clk);
    end
    check(n == WE_LOW, "R6 ack latency", n, WE_LOW);
    check(ram_we_n == 1'b1, "R6 ack with strobe rise", ram_we_n, 1);
    check(lows == WE_LOW, "R3 write strobe width", lows, WE_LOW);
    check(bad_oe == 0, "R3 output enable high in write", bad_oe, 0);
    check(drv == DRV_ON, "R4 data driven cycles before rise", drv, DRV_ON);
    check(bad_addr == 0, "R5 address held", bad_addr, 0);
    check(bad_ce == 0, "R9 strobe only when selected", bad_ce, 0);
    check(mem[a] == d, "R3 word stored", mem[a], d);
    if (sel) ce_cyc++;
    @(negedge clk);
    check(!wr_ack, "R6 ack one cycle", wr_ack, 0);
    check(ce_cyc == CYC, "R8 write enable duration", ce_cyc, CYC);
    check(req_ready && ram_ce_n && !ram_ce, "R8 deselect after write",
          {req_ready, ram_ce_n, ram_ce}, 3'b110);
  endtask

  task automatic t_read(input logic [12:0] a, input logic [7:0] exp);
    int n = 0, bad = 0;
    issue(1'b0, a, ~exp);
    while (!rd_valid && n < 100) begin
      if (ram_oe_n || !ram_we_n || ram_addr !== a || !sel) bad++;
      n++;
      @(negedge clk);
    end
    check(n == CYC, "R7 read latency", n, CYC);
    check(rd_data == exp, "R7 read data", rd_data, exp);
    check(bad == 0, "R7 read strobes", bad, 0);
    check(req_ready && ram_oe_n && !sel, "R8 deselect after read",
          {req_ready, ram_oe_n, sel}, 3'b110);
    @(negedge clk);
    check(!rd_valid, "R7 valid one cycle", rd_valid, 0);
  endtask

  task automatic t_held_request;
    int busy = 0, early = 0, n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0ABC; req_wdata = 8'h5D;
    @(negedge clk);
    req_write = 1'b0; req_addr = 13'h0ABC;
    while (!req_ready && busy < 100) begin
      if (!ram_oe_n) early++;
      busy++;
      @(negedge clk);
    end
    check(busy == CYC, "R2 ready low while busy", busy, CYC);
    check(early == 0, "R2 held request starts nothing", early, 0);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rd_valid && n < 100) begin n++; @(negedge clk); end
    check(rd_data == 8'h5D, "R2 queued read returns written word", rd_data, 8'h5D);
  endtask

  initial begin
    t_reset();
    t_write(13'h0000, 8'hA5);
    t_read(13'h0000, 8'hA5);
    t_write(13'h1FFF, 8'h3C);
    t_read(13'h1FFF, 8'h3C);
    t_read(13'h0123, init_val(13'h0123));
    t_write(13'h0040, 8'hFF);
    t_write(13'h0041, 8'h01);
    t_read(13'h0040, 8'hFF);
    t_read(13'h0041, 8'h01);
    t_held_request();
    repeat (2) @(negedge clk);
    check(req_ready && ram_ce_n && ram_we_n && ram_oe_n, "R1 idle after traffic",
          {req_ready, ram_ce_n, ram_we_n, ram_oe_n}, 4'b1111);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule